// File: doc/BRIEF.md
# Multiplexed Open-Drain I/O Port

This block is a byte-wide general-purpose port built from identical bit slices. Each slice holds an output latch that is loaded from the internal data bus. It also keeps a registered sample of its pad, and it decides how the pad is driven. There are no tri-state nets. Each pad is described by a pull-up enable, a pull-down enable and the level seen at the pad.

In general I/O mode the pad is open-drain. A slice pulls its pad low while its latch bit is 0 and releases it otherwise. A bit written to 1 can therefore be used as an input. Software reads come from one of two paths. Ordinary reads see the pad level. Read-modify-write reads, and explicit latch reads, see the latch instead, so that external loading cannot corrupt the value written back.

In bus mode the port carries the low address byte and then the data byte of an external memory access. During the address phase each pad is driven both ways from the address/data byte. During the data phase both drivers are released and the sampled pads form the returned byte. The start of each bus access overwrites the latch with all ones, and any earlier general I/O value is lost.

Top module: `mux_od_port`

## Requirements
- R1: The latch takes the value on `wr_data` at a clock edge where `wr_en` is 1 and `bus_start` is 0. Without either strobe the latch keeps its value.
- R2: With `bus_mode` = 0, every bit of `pad_pu_en` is 0, and a bit of `pad_pd_en` is 1 exactly when the corresponding latch bit is 0.
- R3: When `rd_latch` is 1, `rd_data` equals the latch. It also equals the latch when `rd_pin` and `rd_rmw` are both 1.
- R4: When `rd_pin` is 1 and `rd_rmw` and `rd_latch` are 0, `rd_data` equals the pad levels sampled at the previous clock edge.
- R5: In I/O mode, a pin read of a bit whose latch holds 0 returns 0 whatever level is applied externally. This holds from the second edge after the write.
- R6: With `bus_mode` = 1 and `bus_phase` = 0 (address out), each bit of `pad_pu_en` equals the `bus_ad` bit and each bit of `pad_pd_en` equals its inverse.
- R7: With `bus_mode` = 1 and `bus_phase` = 1 (data in), both enables are 0 on every bit. `bus_rdata` then equals the pads sampled at the previous edge. Outside that phase `bus_rdata` is 0.
- R8: A clock edge with `bus_start` = 1 loads the latch with all ones. This takes priority over a simultaneous write.
- R9: After reset the latch is all ones, the port is in I/O mode and every pad is released (both enables 0).
- R10: No bit ever has its pull-up and pull-down enables at 1 in the same cycle.
- R11: With neither `rd_pin` nor `rd_latch` at 1, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the latch |
| wr_data | input | W | Value to load into the latch |
| rd_pin | input | 1 | Read request for the pin path |
| rd_latch | input | 1 | Read request for the latch path |
| rd_rmw | input | 1 | Marks a pin read as read-modify-write (served from the latch) |
| rd_data | output | W | Result of the current read request |
| bus_mode | input | 1 | 0 selects general I/O, 1 selects external bus use |
| bus_phase | input | 1 | 0 drives the address out, 1 receives data in |
| bus_ad | input | W | Address/data byte to drive in the address phase |
| bus_start | input | 1 | Marks the start of a bus access; forces the latch to all ones |
| bus_rdata | output | W | Byte returned from the pads during the data phase |
| pad_in | input | W | Level present at each pad |
| pad_pu_en | output | W | Pull-up driver enable per bit |
| pad_pd_en | output | W | Pull-down driver enable per bit |

## Verification
A wrong latch bit shows at `pad_pd_en` in the same cycle in I/O mode. It shows on a latch read at once, and on a pin read one edge later because of the pad sample. A lost or misordered bus-start override shows up on the first latch read after the access. It also shows as a stuck pull-down when the port returns to I/O mode. Driver errors in either bus phase appear at the enables in the very cycle the phase is presented. A wrong pad sample appears in `bus_rdata` one edge after the level is applied.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } bus_phase_e;
endpackage

// File: rtl/port_rst_sync.sv
module port_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_s <= stage_q;
    end
  end
endmodule

// File: rtl/port_bit_slice.sv
module port_bit_slice
  import mdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic       force_one,
  input  logic       bus_mode,
  input  bus_phase_e phase,
  input  logic       ad_bit,
  input  logic       pad_in,
  output logic       latch_q,
  output logic       pin_q,
  output logic       pu_en,
  output logic       pd_en
);
  logic latch_d;
  logic latch_ce;

  // next-state: bus start wins over a data write
  always_comb begin
    latch_ce = force_one | wr_en;
    latch_d  = force_one ? 1'b1 : wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      pin_q   <= 1'b1;
    end else begin
      if (latch_ce) latch_q <= latch_d;
      pin_q <= pad_in;
    end
  end

  // driver selection
  always_comb begin
    pu_en = 1'b0;
    pd_en = 1'b0;
    if (!bus_mode) begin
      pd_en = ~latch_q;
    end else if (phase == PH_ADDR) begin
      pu_en = ad_bit;
      pd_en = ~ad_bit;
    end
  end

  // R10
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en && pd_en));

  // R2
  io_pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> !pu_en);

  // R1
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !force_one) |=> $stable(latch_q));
endmodule

// File: rtl/port_read_sel.sv
module port_read_sel #(
  parameter int W = 8
) (
  input  logic         rd_pin,
  input  logic         rd_latch,
  input  logic         rd_rmw,
  input  logic [W-1:0] latch_v,
  input  logic [W-1:0] pin_v,
  output logic [W-1:0] rd_data
);
  logic use_latch;

  always_comb begin
    use_latch = rd_latch | (rd_pin & rd_rmw);
    if (use_latch)   rd_data = latch_v;
    else if (rd_pin) rd_data = pin_v;
    else             rd_data = '0;
  end
endmodule

// File: rtl/mux_od_port.sv
module mux_od_port
  import mdp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pin,
  input  logic         rd_latch,
  input  logic         rd_rmw,
  output logic [W-1:0] rd_data,
  input  logic         bus_mode,
  input  logic         bus_phase,
  input  logic [W-1:0] bus_ad,
  input  logic         bus_start,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_pu_en,
  output logic [W-1:0] pad_pd_en
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic         rst_n_s;
  bus_phase_e   phase;
  logic [W-1:0] latch_v;
  logic [W-1:0] pin_v;

  assign phase = bus_phase_e'(bus_phase);

  port_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    port_bit_slice u_bit (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .wr_en     (wr_en),
      .wr_bit    (wr_data[i]),
      .force_one (bus_start),
      .bus_mode  (bus_mode),
      .phase     (phase),
      .ad_bit    (bus_ad[i]),
      .pad_in    (pad_in[i]),
      .latch_q   (latch_v[i]),
      .pin_q     (pin_v[i]),
      .pu_en     (pad_pu_en[i]),
      .pd_en     (pad_pd_en[i])
    );
  end

  port_read_sel #(.W(W)) u_rd (
    .rd_pin   (rd_pin),
    .rd_latch (rd_latch),
    .rd_rmw   (rd_rmw),
    .latch_v  (latch_v),
    .pin_v    (pin_v),
    .rd_data  (rd_data)
  );

  assign bus_rdata = (bus_mode && phase == PH_DATA) ? pin_v : '0;

  // R8
  force_ff_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_start |=> (latch_v == ALL_ONES));

  // R7
  data_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_mode && phase == PH_DATA) |-> (pad_pu_en == '0 && pad_pd_en == '0));

  // R6
  addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_mode && phase == PH_ADDR) |-> (pad_pu_en == bus_ad && pad_pd_en == ~bus_ad));
endmodule

// File: tb/mux_od_port_bench.sv
module mux_od_port_bench;
  localparam int W = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_pin, rd_latch, rd_rmw, bus_mode, bus_phase, bus_start;
  logic [W-1:0] wr_data, bus_ad, ext;
  logic [W-1:0] rd_data, bus_rdata, pad_pu_en, pad_pd_en, pad_in;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // external world: pull-down wins, then pull-up, else the applied level
  assign pad_in = (ext & ~pad_pd_en) | (pad_pu_en & ~pad_pd_en);

  always #(PERIOD/2) clk = ~clk;

  mux_od_port #(.W(W)) u_mux_od_port (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin(rd_pin), .rd_latch(rd_latch), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .bus_mode(bus_mode), .bus_phase(bus_phase), .bus_ad(bus_ad),
    .bus_start(bus_start), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] m_lat, m_pin;

  function automatic logic [W-1:0] e_pu();
    if (bus_mode && !bus_phase) return bus_ad;
    return '0;
  endfunction

  function automatic logic [W-1:0] e_pd();
    if (!bus_mode) return ~m_lat;
    if (!bus_phase) return ~bus_ad;
    return '0;
  endfunction

  function automatic logic [W-1:0] e_rd();
    if (rd_latch || (rd_pin && rd_rmw)) return m_lat;
    if (rd_pin) return m_pin;
    return '0;
  endfunction

  function automatic logic [W-1:0] e_brd();
    return (bus_mode && bus_phase) ? m_pin : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat <= '1;
      m_pin <= '1;
    end else begin
      if (bus_start)  m_lat <= '1;
      else if (wr_en) m_lat <= wr_data;
      m_pin <= (ext & ~e_pd()) | (e_pu() & ~e_pd());
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R6/R7 pull-up", pad_pu_en, e_pu());
    chk("R2/R6/R7 pull-down", pad_pd_en, e_pd());
    chk("R3/R4/R11 read data", rd_data, e_rd());
    chk("R7 bus return", bus_rdata, e_brd());
    // R10
    chk("R10 contention", pad_pu_en & pad_pd_en, '0);
  endtask

  task automatic cyc();
    @(negedge clk);
    if (cmp_en) compare_all();
  endtask

  task automatic idle();
    wr_en = 0; rd_pin = 0; rd_latch = 0; rd_rmw = 0;
    bus_start = 0;
  endtask

  initial begin
    rst_n = 0; idle(); bus_mode = 0; bus_phase = 0;
    wr_data = '0; bus_ad = '0; ext = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    // R9 reset state
    chk("R9 pull-up after reset", pad_pu_en, '0);
    chk("R9 pull-down after reset", pad_pd_en, '0);
    rd_latch = 1; #1;
    chk("R9 latch after reset", rd_data, 8'hFF);
    idle();

    // R1 write
    wr_en = 1; wr_data = 8'h5A;
    cyc(); idle();
    chk("R2 pull-down follows latch", pad_pd_en, 8'hA5);
    cyc();
    // R5 pin read of zeros with external high
    rd_pin = 1; #1;
    chk("R5 pin read masks zeros", rd_data, 8'h5A);
    ext = 8'h0F;
    cyc();
    chk("R4 pin read", rd_data, 8'h0A);
    rd_rmw = 1; #1;
    chk("R3 rmw read from latch", rd_data, 8'h5A);
    rd_rmw = 0; rd_pin = 0; rd_latch = 1; #1;
    chk("R3 latch read", rd_data, 8'h5A);
    rd_latch = 0; #1;
    chk("R11 no request", rd_data, 8'h00);

    // R1 hold over several cycles
    repeat (5) cyc();
    rd_latch = 1; #1;
    chk("R1 latch holds", rd_data, 8'h5A);
    idle();

    // R6 address phase
    bus_mode = 1; bus_phase = 0; bus_ad = 8'hC3; #1;
    chk("R6 address pull-up", pad_pu_en, 8'hC3);
    chk("R6 address pull-down", pad_pd_en, 8'h3C);
    // R8 bus start beats a write
    bus_start = 1; wr_en = 1; wr_data = 8'h12;
    cyc(); idle();
    rd_latch = 1; #1;
    chk("R8 latch forced to ones", rd_data, 8'hFF);
    idle();

    // R7 data phase
    bus_phase = 1; ext = 8'h96; #1;
    chk("R7 pull-up released", pad_pu_en, 8'h00);
    chk("R7 pull-down released", pad_pd_en, 8'h00);
    cyc();
    chk("R7 returned byte", bus_rdata, 8'h96);

    // back to I/O: old value lost
    bus_mode = 0; bus_phase = 0; #1;
    chk("R8 old value lost", pad_pd_en, 8'h00);

    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      cyc();
      wr_en     = ($urandom % 4) == 0;
      wr_data   = W'($urandom);
      rd_pin    = $urandom % 2;
      rd_latch  = ($urandom % 4) == 0;
      rd_rmw    = $urandom % 2;
      bus_mode  = ($urandom % 3) == 0;
      bus_phase = $urandom % 2;
      bus_ad    = W'($urandom);
      bus_start = ($urandom % 8) == 0;
      ext       = W'($urandom);
    end
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule